// File: doc/BRIEF.md
# Loadable Wiper Position Counter

This block holds the 8-bit position of one potentiometer wiper and drives a 256-way tap select for the resistor ladder. A host serial interface and a bank of four stored setting registers sit outside the block. That outside logic hands in decoded strobes, a bank selector and data. The block only decides what the position becomes on each clock.

The position can change in five ways:
- a direct host write of an 8-bit value;
- a parallel copy from one of the four stored settings;
- a single step up or down, which saturates at either end;
- a recall of stored setting 0, requested by a strobe;
- an automatic recall of stored setting 0 on the first clock after reset.

Code 0x00 is the tap nearest the low terminal. Code 0xFF is the tap nearest the high terminal.

Top module: `wiper_pos_counter`

## Requirements
- R1: While `rst_n` is low, `pos_o` is 0x00 and `tap_o` has only bit 0 set. On the first rising clock edge after `rst_n` goes high, `pos_o` loads stored setting 0 (`dr_bank_i[7:0]`), whatever strobes are present.
- R2: With `recall_i` high at a clock edge, `pos_o` loads `dr_bank_i[7:0]`.
- R3: With `wr_i` high and no recall, `pos_o` loads `wr_data_i` at the clock edge.
- R4: With `xfer_i` high and no recall or write, `pos_o` loads the stored setting picked by `xfer_sel_i`. Selector value n picks `dr_bank_i[8n+7:8n]`.
- R5: With `step_i` high and no other strobe, `pos_o` moves by exactly one. It goes up when `step_up_i` is 1 and down when `step_up_i` is 0.
- R6: A step up at 0xFF leaves 0xFF, and a step down at 0x00 leaves 0x00. The value never wraps.
- R7: When several strobes meet in one cycle, the priority is recall (strobe or post-reset), then write, then transfer, then step.
- R8: `tap_o` always has exactly one bit set. That bit is bit k, where k is the value `pos_o` held one clock earlier. Bit 0 is the low-terminal tap.
- R9: With no strobe and no pending post-reset recall, `pos_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_i | input | 1 | Recall stored setting 0 |
| wr_i | input | 1 | Direct host write strobe |
| wr_data_i | input | 8 | Host write value |
| xfer_i | input | 1 | Transfer-from-bank strobe |
| xfer_sel_i | input | 2 | Bank selector for transfer |
| dr_bank_i | input | 32 | Four stored settings, setting n in bits [8n+7:8n] |
| step_i | input | 1 | Single-step strobe |
| step_up_i | input | 1 | Step direction, 1 means up |
| pos_o | output | 8 | Wiper position |
| tap_o | output | 256 | Registered one-hot tap select |

## Verification
The embedded properties check these behaviours on every cycle:
- the write load;
- single steps up and down;
- saturation at both ends;
- holding when idle;
- the one-hot shape and one-cycle lag of the tap select.

Only the bench scenarios can show three other behaviours:
- the post-reset recall, and that it overrides a simultaneous write;
- the selection among the four stored settings;
- the full priority order when every strobe fires at once.

Those scenarios, and the random traffic, are compared against a bench reference model.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_RECALL,
    SRC_WRITE,
    SRC_XFER,
    SRC_STEP
  } load_src_e;
endpackage

// File: rtl/wiper_load_arbiter.sv
module wiper_load_arbiter
  import wiper_pkg::*;
(
  input  logic      recall_i,
  input  logic      wr_i,
  input  logic      xfer_i,
  input  logic      step_i,
  output load_src_e src_o
);
  // Fixed priority: recall > write > transfer > step
  always_comb begin
    if (recall_i)    src_o = SRC_RECALL;
    else if (wr_i)   src_o = SRC_WRITE;
    else if (xfer_i) src_o = SRC_XFER;
    else if (step_i) src_o = SRC_STEP;
    else             src_o = SRC_HOLD;
  end
endmodule

// File: rtl/wiper_next_value.sv
module wiper_next_value
  import wiper_pkg::*;
#(
  parameter int W   = 8,
  parameter int NDR = 4,
  localparam int SELW = (NDR > 1) ? $clog2(NDR) : 1
) (
  input  load_src_e       src_i,
  input  logic [W-1:0]    pos_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic [NDR*W-1:0] dr_bank_i,
  input  logic [SELW-1:0] sel_i,
  input  logic            step_up_i,
  output logic [W-1:0]    pos_o
);
  localparam logic [W-1:0] POS_MAX = {W{1'b1}};
  localparam logic [W-1:0] POS_MIN = '0;

  logic [W-1:0] bank [NDR];

  for (genvar g = 0; g < NDR; g++) begin : g_unpack
    assign bank[g] = dr_bank_i[g*W +: W];
  end

  logic [W-1:0] step_val;
  always_comb begin
    if (step_up_i) step_val = (pos_i == POS_MAX) ? POS_MAX : pos_i + W'(1);
    else           step_val = (pos_i == POS_MIN) ? POS_MIN : pos_i - W'(1);
  end

  always_comb begin
    unique case (src_i)
      SRC_RECALL: pos_o = bank[0];
      SRC_WRITE:  pos_o = wr_data_i;
      SRC_XFER:   pos_o = bank[sel_i];
      SRC_STEP:   pos_o = step_val;
      default:    pos_o = pos_i;
    endcase
  end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int W = 8,
  localparam int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    pos_i,
  output logic [TAPS-1:0] tap_o
);
  logic [TAPS-1:0] tap_d;

  for (genvar g = 0; g < TAPS; g++) begin : g_dec
    assign tap_d[g] = (pos_i == W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_o <= TAPS'(1);
    else        tap_o <= tap_d;
  end

  // R8
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_o) == 1);

  // R8
  tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tap_o == (TAPS'(1) << $past(pos_i)));
endmodule

// File: rtl/wiper_pos_counter.sv
module wiper_pos_counter
  import wiper_pkg::*;
#(
  parameter int W   = 8,
  parameter int NDR = 4,
  localparam int SELW = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            recall_i,
  input  logic            wr_i,
  input  logic [W-1:0]    wr_data_i,
  input  logic            xfer_i,
  input  logic [SELW-1:0] xfer_sel_i,
  input  logic [NDR*W-1:0] dr_bank_i,
  input  logic            step_i,
  input  logic            step_up_i,
  output logic [W-1:0]    pos_o,
  output logic [TAPS-1:0] tap_o
);
  localparam logic [W-1:0] POS_MAX = {W{1'b1}};

  logic      pend_q;
  logic      recall_any;
  load_src_e src;
  logic [W-1:0] pos_d;
  logic      pos_en;

  // One-shot recall of setting 0 after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= 1'b0;
  end

  assign recall_any = recall_i | pend_q;

  wiper_load_arbiter u_arb (
    .recall_i (recall_any),
    .wr_i     (wr_i),
    .xfer_i   (xfer_i),
    .step_i   (step_i),
    .src_o    (src)
  );

  wiper_next_value #(.W(W), .NDR(NDR)) u_next (
    .src_i     (src),
    .pos_i     (pos_o),
    .wr_data_i (wr_data_i),
    .dr_bank_i (dr_bank_i),
    .sel_i     (xfer_sel_i),
    .step_up_i (step_up_i),
    .pos_o     (pos_d)
  );

  assign pos_en = (src != SRC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_o <= '0;
    else if (pos_en) pos_o <= pos_d;
  end

  wiper_tap_decode #(.W(W)) u_tap (
    .clk   (clk),
    .rst_n (rst_n),
    .pos_i (pos_o),
    .tap_o (tap_o)
  );

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !recall_i && !pend_q) |=> pos_o == $past(wr_data_i));

  // R5
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && step_up_i && !wr_i && !xfer_i && !recall_i && !pend_q && pos_o != POS_MAX)
      |=> pos_o == $past(pos_o) + W'(1));

  // R5
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !step_up_i && !wr_i && !xfer_i && !recall_i && !pend_q && pos_o != '0)
      |=> pos_o == $past(pos_o) - W'(1));

  // R6
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && step_up_i && !wr_i && !xfer_i && !recall_i && !pend_q && pos_o == POS_MAX)
      |=> pos_o == POS_MAX);

  // R6
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !step_up_i && !wr_i && !xfer_i && !recall_i && !pend_q && pos_o == '0)
      |=> pos_o == '0);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !wr_i && !xfer_i && !recall_i && !pend_q) |=> $stable(pos_o));
endmodule

// File: tb/tb_wiper_pos_counter.sv
`timescale 1ns/1ps
module tb_wiper_pos_counter;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         recall_i, wr_i, xfer_i, step_i, step_up_i;
  logic [7:0]   wr_data_i;
  logic [1:0]   xfer_sel_i;
  logic [31:0]  dr_bank_i;
  logic [7:0]   pos_o;
  logic [255:0] tap_o;

  int total = 0;
  int bad   = 0;

  logic [7:0] m_pos;
  logic [7:0] m_prev;
  bit         m_pend;

  always #5 clk = ~clk;

  wiper_pos_counter dut (
    .clk(clk), .rst_n(rst_n), .recall_i(recall_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .xfer_i(xfer_i), .xfer_sel_i(xfer_sel_i),
    .dr_bank_i(dr_bank_i), .step_i(step_i), .step_up_i(step_up_i),
    .pos_o(pos_o), .tap_o(tap_o)
  );

  function automatic logic [7:0] ref_next(logic [7:0] p, bit pend, bit rc, bit wr,
      logic [7:0] wd, bit xf, logic [1:0] sel, bit st, bit up, logic [31:0] bank);
    if (pend || rc) return bank[7:0];
    if (wr)         return wd;
    if (xf)         return bank[sel*8 +: 8];
    if (st) begin
      if (up) return (p == 8'hFF) ? 8'hFF : p + 8'd1;
      else    return (p == 8'h00) ? 8'h00 : p - 8'd1;
    end
    return p;
  endfunction

  task automatic check_pos(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s pos actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic check_tap(logic [255:0] got, logic [7:0] k);
    total++;
    if (got !== (256'd1 << k)) begin
      bad++;
      $display("FAIL R8 tap actual=%064h expected bit %0d", got, k);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, check at the next falling edge
  task automatic cyc(string tag, bit rc, bit wr, logic [7:0] wd, bit xf,
                     logic [1:0] sel, bit st, bit up);
    recall_i = rc; wr_i = wr; wr_data_i = wd; xfer_i = xf;
    xfer_sel_i = sel; step_i = st; step_up_i = up;
    @(posedge clk);
    m_prev = m_pos;
    m_pos  = ref_next(m_pos, m_pend, rc, wr, wd, xf, sel, st, up, dr_bank_i);
    m_pend = 1'b0;
    @(negedge clk);
    check_pos(tag, pos_o, m_pos);
    check_tap(tap_o, m_prev);
  endtask

  task automatic do_reset(logic [31:0] bank);
    rst_n = 1'b0;
    dr_bank_i = bank;
    recall_i = 0; wr_i = 0; xfer_i = 0; step_i = 0; step_up_i = 0;
    wr_data_i = '0; xfer_sel_i = '0;
    repeat (2) @(negedge clk);
    // R1: state held in reset
    check_pos("R1", pos_o, 8'h00);
    check_tap(tap_o, 8'h00);
    rst_n  = 1'b1;
    m_pos  = 8'h00;
    m_pend = 1'b1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    do_reset(32'h44_33_22_A5);
    // R1 / R7: post-reset recall beats a simultaneous write
    cyc("R1", 0, 1, 8'h77, 0, 0, 0, 0);
    // R9: idle holds
    cyc("R9", 0, 0, 8'h00, 0, 0, 0, 0);
    cyc("R9", 0, 0, 8'h00, 0, 0, 0, 0);
    // R3: direct write
    cyc("R3", 0, 1, 8'h10, 0, 0, 0, 0);
    // R4: transfer from each setting
    for (int s = 0; s < 4; s++) cyc("R4", 0, 0, 8'h00, 1, 2'(s), 0, 0);
    // R5: single steps
    cyc("R3", 0, 1, 8'h80, 0, 0, 0, 0);
    cyc("R5", 0, 0, 8'h00, 0, 0, 1, 1);
    cyc("R5", 0, 0, 8'h00, 0, 0, 1, 0);
    cyc("R5", 0, 0, 8'h00, 0, 0, 1, 0);
    // R6: saturation at both ends
    cyc("R3", 0, 1, 8'hFE, 0, 0, 0, 0);
    cyc("R6", 0, 0, 8'h00, 0, 0, 1, 1);
    cyc("R6", 0, 0, 8'h00, 0, 0, 1, 1);
    cyc("R3", 0, 1, 8'h01, 0, 0, 0, 0);
    cyc("R6", 0, 0, 8'h00, 0, 0, 1, 0);
    cyc("R6", 0, 0, 8'h00, 0, 0, 1, 0);
    // R7: priority ladder
    cyc("R7", 1, 1, 8'h5C, 1, 2'd3, 1, 1);
    cyc("R7", 0, 1, 8'h5C, 1, 2'd3, 1, 1);
    cyc("R7", 0, 0, 8'h00, 1, 2'd2, 1, 1);
    // R2: recall after setting 0 changes
    dr_bank_i[7:0] = 8'h3E;
    cyc("R2", 1, 0, 8'h00, 0, 0, 0, 0);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) dr_bank_i = $urandom;
      cyc("R7", ($urandom % 16) == 0, ($urandom % 5) == 0, 8'($urandom),
          ($urandom % 5) == 0, 2'($urandom), ($urandom % 2) == 0, ($urandom % 2) == 0);
    end
    // R1: second reset with a different setting 0
    do_reset(32'h01_02_03_C7);
    cyc("R1", 0, 0, 8'h00, 1, 2'd1, 1, 1);
    cyc("R9", 0, 0, 8'h00, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule